// File: doc/BRIEF.md
# Endpoint Ping-Pong Buffer Descriptor Manager

This block looks after the two buffer descriptors of one device-side data endpoint. Each descriptor is a 32-bit word with three fields: an ownership flag, a remaining byte count and a start address. Software gives a buffer to the hardware by clearing the ownership flag. The hardware then fills or drains the buffer one packet at a time. After each good packet it moves the address forward and reduces the remaining count. When the buffer is finished, it sets the flag again to return the buffer to software and signals a one-cycle completion event.

For every token that arrives, the block chooses between accepting the transaction and refusing it with NAK. The choice depends only on who owns the currently selected buffer. When a buffer completes, the selector moves to the other buffer, so the two buffers alternate starting from buffer 0. A plain write port lets the processor program either descriptor. Both descriptors and the fields of the active buffer are visible on output ports. A byte count reported with each transaction outcome takes the place of the real data path.

Top module: `epbuf_pingpong`

## Requirements
- R1: After reset, both descriptor words read 0xFFFFFFFF, the buffer selector is 0 and no completion event is asserted.
- R2: Descriptor layout: bit 31 is the ownership flag (1 = software owns it, 0 = hardware owns it), bits 30:17 are the remaining size and bits 16:0 are the start address. A processor write to a software-owned descriptor replaces the whole word, and the new value is visible after the next clock edge.
- R3: While a token request is present, the block asserts NAK (and not accept) in the same cycle if the selected buffer's flag is 1. It asserts accept (and not NAK) if the flag is 0.
- R4: A successful transaction of N bytes on the selected hardware-owned buffer reduces its size by N and adds N to its address at the next edge. If the buffer has not completed, the selector does not change.
- R5: In IN direction, a buffer completes when its remaining size reaches zero.
- R6: In OUT direction, a buffer completes on a short packet (N below the max packet size) or when the remaining size falls below the max packet size.
- R7: On completion, the buffer's flag becomes 1 and the selector toggles at the same edge. One cycle later, the completion bit for that buffer (bit 0 or bit 1) is high for exactly one cycle.
- R8: A transaction reported as failed leaves both descriptors and the selector unchanged.
- R9: A processor write to a hardware-owned descriptor is ignored, with one exception: if the write has bit 31 set, the flag is set to 1 and the size and address are kept.
- R10: If software never releases buffer 1, then after buffer 0 completes every request receives NAK. The endpoint then runs with a single buffer.
- R11: A byte count larger than the remaining size is clamped to that size. The address advances only by the clamped amount.
- R12: A transaction outcome that arrives while the selected buffer is owned by software changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint (device sends), 0 = OUT |
| cfg_max_pkt | input | 11 | Max packet size in bytes |
| wr_en | input | 1 | Processor descriptor write strobe |
| wr_sel | input | 1 | Descriptor targeted by the write |
| wr_data | input | 32 | Descriptor word to write |
| txn_req | input | 1 | Token for this endpoint is present |
| rsp_accept | output | 1 | Transaction may proceed |
| rsp_nak | output | 1 | Answer the host with NAK |
| txn_done | input | 1 | Transaction outcome strobe |
| txn_ok | input | 1 | Outcome was successful |
| txn_bytes | input | 11 | Bytes moved by the transaction |
| act_sel | output | 1 | Currently selected buffer |
| act_ptr | output | 17 | Address of the selected buffer |
| act_size | output | 14 | Remaining size of the selected buffer |
| desc0 | output | 32 | Descriptor word of buffer 0 |
| desc1 | output | 32 | Descriptor word of buffer 1 |
| buf_done | output | 2 | One-cycle completion event per buffer |

## Verification
The hardest case to reach is the one where the processor writes to a descriptor while the hardware owns it. This only matters in the middle of a transfer, after the buffer has been released and partly consumed. To get there, the stimulus first completes buffer 0, then releases buffer 1, and then sends both an ordinary overwrite and an ownership-reclaim write to that buffer. After each write, the descriptor is read back on its port. The OUT completion paths are reached by choosing sizes that fall below the max packet size on a full packet, and a separate case ends a transfer with a short packet. The clamp case uses a byte count larger than the space left in the buffer.

// File: rtl/epb_pkg.sv
package epb_pkg;
    localparam int SZ_W   = 14;
    localparam int PT_W   = 17;
    localparam int DESC_W = 1 + SZ_W + PT_W;

    // Field order is fixed: ownership flag at the top, address at the bottom.
    typedef struct packed {
        logic            used;
        logic [SZ_W-1:0] size;
        logic [PT_W-1:0] ptr;
    } desc_t;

    typedef struct packed {
        desc_t [1:0] desc;
        logic        sel;
        logic [1:0]  pend;
        logic [1:0]  evt;
    } epb_state_t;
endpackage

// File: rtl/epb_desc_upd.sv
module epb_desc_upd
    import epb_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  desc_t             cur_i,
    input  logic              hit_i,
    input  logic              dir_in_i,
    input  logic [CNT_W-1:0]  bytes_i,
    input  logic [CNT_W-1:0]  max_pkt_i,
    input  logic              wr_en_i,
    input  logic [DESC_W-1:0] wr_data_i,
    output desc_t             nxt_o,
    output logic              done_o
);
    localparam int PAD = SZ_W - CNT_W;

    logic [SZ_W-1:0] bytes_ext;
    logic [SZ_W-1:0] mpk_ext;
    logic [SZ_W-1:0] take;
    logic [SZ_W-1:0] left;
    logic            complete;
    desc_t           wr_desc;

    always_comb begin
        bytes_ext = {{PAD{1'b0}}, bytes_i};
        mpk_ext   = {{PAD{1'b0}}, max_pkt_i};
        take      = (bytes_ext > cur_i.size) ? cur_i.size : bytes_ext;
        left      = cur_i.size - take;
        if (dir_in_i) complete = (left == '0);
        else          complete = (bytes_ext < mpk_ext) || (left < mpk_ext);
        wr_desc   = desc_t'(wr_data_i);

        nxt_o  = cur_i;
        done_o = 1'b0;
        if (hit_i) begin
            nxt_o.size = left;
            nxt_o.ptr  = cur_i.ptr + {{(PT_W-SZ_W){1'b0}}, take};
            nxt_o.used = complete;
            done_o     = complete;
        end
        if (wr_en_i) begin
            if (cur_i.used)        nxt_o      = wr_desc;
            else if (wr_desc.used) nxt_o.used = 1'b1;
        end
    end
endmodule

// File: rtl/epb_select.sv
module epb_select
    import epb_pkg::*;
(
    input  desc_t       d0_i,
    input  desc_t       d1_i,
    input  logic        sel_i,
    input  logic        req_i,
    output desc_t       act_o,
    output logic        accept_o,
    output logic        nak_o
);
    always_comb begin
        act_o    = sel_i ? d1_i : d0_i;
        accept_o = req_i & ~act_o.used;
        nak_o    = req_i &  act_o.used;
    end
endmodule

// File: rtl/epbuf_pingpong.sv
module epbuf_pingpong
    import epb_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dir_in,
    input  logic [CNT_W-1:0]  cfg_max_pkt,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              txn_req,
    output logic              rsp_accept,
    output logic              rsp_nak,
    input  logic              txn_done,
    input  logic              txn_ok,
    input  logic [CNT_W-1:0]  txn_bytes,
    output logic              act_sel,
    output logic [PT_W-1:0]   act_ptr,
    output logic [SZ_W-1:0]   act_size,
    output logic [DESC_W-1:0] desc0,
    output logic [DESC_W-1:0] desc1,
    output logic [1:0]        buf_done
);
    localparam int NBUF = 2;

    epb_state_t  st_q, st_d;
    desc_t [NBUF-1:0] nxt_desc;
    logic  [NBUF-1:0] hit;
    logic  [NBUF-1:0] fin;
    desc_t            act;

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        always_comb hit[g] = txn_done & txn_ok & (st_q.sel == 1'(g))
                             & ~st_q.desc[g].used;
        epb_desc_upd #(.CNT_W(CNT_W)) u_upd (
            .cur_i     (st_q.desc[g]),
            .hit_i     (hit[g]),
            .dir_in_i  (cfg_dir_in),
            .bytes_i   (txn_bytes),
            .max_pkt_i (cfg_max_pkt),
            .wr_en_i   (wr_en && (wr_sel == 1'(g))),
            .wr_data_i (wr_data),
            .nxt_o     (nxt_desc[g]),
            .done_o    (fin[g])
        );
    end

    epb_select u_sel (
        .d0_i     (st_q.desc[0]),
        .d1_i     (st_q.desc[1]),
        .sel_i    (st_q.sel),
        .req_i    (txn_req),
        .act_o    (act),
        .accept_o (rsp_accept),
        .nak_o    (rsp_nak)
    );

    always_comb begin
        st_d      = st_q;
        st_d.desc = nxt_desc;
        st_d.sel  = st_q.sel ^ (|fin);
        st_d.pend = fin;
        st_d.evt  = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.desc <= {NBUF{desc_t'({DESC_W{1'b1}})}};
            st_q.sel  <= 1'b0;
            st_q.pend <= '0;
            st_q.evt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel  = st_q.sel;
    assign act_ptr  = act.ptr;
    assign act_size = act.size;
    assign desc0    = st_q.desc[0];
    assign desc1    = st_q.desc[1];
    assign buf_done = st_q.evt;
endmodule

// File: rtl/epbuf_pingpong_chk.sv
module epbuf_pingpong_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        txn_req,
    input logic        txn_done,
    input logic        txn_ok,
    input logic        wr_en,
    input logic        wr_sel,
    input logic        rsp_accept,
    input logic        rsp_nak,
    input logic        act_sel,
    input logic [31:0] desc0,
    input logic [31:0] desc1,
    input logic [1:0]  buf_done
);
    AST_NAK_ON_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && (act_sel ? desc1[31] : desc0[31])) |-> (rsp_nak && !rsp_accept)); // R3

    AST_ACCEPT_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !(act_sel ? desc1[31] : desc0[31])) |-> (rsp_accept && !rsp_nak)); // R3

    AST_DONE0_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done[0] |-> (desc0[31] && $past(desc0[31]))); // R7

    AST_DONE1_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done[1] |-> (desc1[31] && $past(desc1[31]))); // R7

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_done)); // R7

    AST_TOGGLE_THEN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |=> (buf_done != 2'b00)); // R7

    AST_FAIL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !txn_ok && !wr_en) |=> ($stable(desc0) && $stable(desc1) && $stable(act_sel))); // R8

    AST_OWNED_WRITE_KEEPS0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !desc0[31] && !txn_done) |=> (desc0[30:0] == $past(desc0[30:0]))); // R9
endmodule

bind epbuf_pingpong epbuf_pingpong_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_req    (txn_req),
    .txn_done   (txn_done),
    .txn_ok     (txn_ok),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .rsp_accept (rsp_accept),
    .rsp_nak    (rsp_nak),
    .act_sel    (act_sel),
    .desc0      (desc0),
    .desc1      (desc1),
    .buf_done   (buf_done)
);

// File: tb/tb_epbuf_pingpong.sv
module tb_epbuf_pingpong;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dir_in = 1'b1;
    logic [10:0] cfg_max_pkt = 11'd64;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        txn_req = 1'b0;
    logic        rsp_accept, rsp_nak;
    logic        txn_done = 1'b0;
    logic        txn_ok = 1'b0;
    logic [10:0] txn_bytes = '0;
    logic        act_sel;
    logic [16:0] act_ptr;
    logic [13:0] act_size;
    logic [31:0] desc0, desc1;
    logic [1:0]  buf_done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2ns clk = ~clk;

    epbuf_pingpong dut (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_max_pkt(cfg_max_pkt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .txn_req(txn_req), .rsp_accept(rsp_accept), .rsp_nak(rsp_nak),
        .txn_done(txn_done), .txn_ok(txn_ok), .txn_bytes(txn_bytes),
        .act_sel(act_sel), .act_ptr(act_ptr), .act_size(act_size),
        .desc0(desc0), .desc1(desc1), .buf_done(buf_done)
    );

    function automatic logic [31:0] mk(input logic u, input int sz, input int pt);
        return {u, 14'(sz), 17'(pt)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_desc(input logic s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_txn(input logic ok, input int nb);
        txn_done = 1'b1; txn_ok = ok; txn_bytes = 11'(nb);
        @(negedge clk);
        txn_done = 1'b0; txn_ok = 1'b0;
    endtask

    task automatic probe(input string tag, input logic exp_acc, input logic exp_nak);
        txn_req = 1'b1;
        #1ns;
        chk({tag, " accept"}, 32'(rsp_accept), 32'(exp_acc));
        chk({tag, " nak"},    32'(rsp_nak),    32'(exp_nak));
        @(negedge clk);
        txn_req = 1'b0;
    endtask

    // completion: flag already visible, event follows one cycle later for one cycle
    task automatic expect_done(input string tag, input logic [1:0] ev);
        chk({tag, " event not yet"}, 32'(buf_done), 32'd0);
        @(negedge clk);
        chk({tag, " event pulse"}, 32'(buf_done), 32'(ev));
        @(negedge clk);
        chk({tag, " event gone"}, 32'(buf_done), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 desc0", desc0, 32'hFFFF_FFFF);
        chk("R1 desc1", desc1, 32'hFFFF_FFFF);
        chk("R1 sel", 32'(act_sel), 32'd0);
        chk("R1 done", 32'(buf_done), 32'd0);
        probe("R3 owned at reset", 1'b0, 1'b1);
    endtask

    task automatic t_program;
        write_desc(1'b0, mk(1'b0, 128, 'h100));
        chk("R2 desc0 readback", desc0, mk(1'b0, 128, 'h100));
        chk("R2 act_size", 32'(act_size), 32'd128);
        chk("R2 act_ptr", 32'(act_ptr), 32'h100);
        probe("R3 free", 1'b1, 1'b0);
    endtask

    task automatic t_in_flow;
        cfg_dir_in = 1'b1;
        run_txn(1'b1, 64);
        chk("R4 partial desc0", desc0, mk(1'b0, 64, 'h140));
        chk("R4 sel held", 32'(act_sel), 32'd0);
        run_txn(1'b0, 32);
        chk("R8 failed desc0", desc0, mk(1'b0, 64, 'h140));
        chk("R8 failed sel", 32'(act_sel), 32'd0);
        run_txn(1'b1, 64);
        chk("R5 IN empty desc0", desc0, mk(1'b1, 0, 'h180));
        chk("R7 sel toggled", 32'(act_sel), 32'd1);
        expect_done("R7 buf0", 2'b01);
    endtask

    task automatic t_single;
        probe("R10 buffer1 never released", 1'b0, 1'b1);
        run_txn(1'b1, 16);
        chk("R12 ignored desc1", desc1, 32'hFFFF_FFFF);
        chk("R12 ignored sel", 32'(act_sel), 32'd1);
        chk("R12 no event", 32'(buf_done), 32'd0);
        probe("R10 still nak", 1'b0, 1'b1);
    endtask

    task automatic t_owned_write;
        write_desc(1'b1, mk(1'b0, 100, 'h200));
        chk("R2 desc1 release", desc1, mk(1'b0, 100, 'h200));
        write_desc(1'b1, mk(1'b0, 5, 'h7));
        chk("R9 overwrite ignored", desc1, mk(1'b0, 100, 'h200));
        write_desc(1'b1, mk(1'b1, 5, 'h7));
        chk("R9 reclaim keeps fields", desc1, mk(1'b1, 100, 'h200));
        probe("R9 reclaimed nak", 1'b0, 1'b1);
        write_desc(1'b1, mk(1'b0, 100, 'h200));
        chk("R9 released again", desc1, mk(1'b0, 100, 'h200));
    endtask

    task automatic t_out;
        cfg_dir_in = 1'b0;
        run_txn(1'b1, 64);
        chk("R6 remaining below max", desc1, mk(1'b1, 36, 'h240));
        chk("R6 sel back to 0", 32'(act_sel), 32'd0);
        expect_done("R7 buf1", 2'b10);
        write_desc(1'b0, mk(1'b0, 200, 'h0));
        run_txn(1'b1, 64);
        chk("R6 full packet continues", desc0, mk(1'b0, 136, 'h40));
        chk("R6 sel held", 32'(act_sel), 32'd0);
        run_txn(1'b1, 10);
        chk("R6 short packet ends", desc0, mk(1'b1, 126, 'h4A));
        chk("R6 sel toggled", 32'(act_sel), 32'd1);
        expect_done("R6 buf0", 2'b01);
    endtask

    task automatic t_clamp;
        cfg_dir_in = 1'b1;
        write_desc(1'b1, mk(1'b0, 20, 'h10));
        run_txn(1'b1, 64);
        chk("R11 clamped desc1", desc1, mk(1'b1, 0, 'h24));
        chk("R11 sel", 32'(act_sel), 32'd0);
        expect_done("R11 buf1", 2'b10);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_in_flow();
        t_single();
        t_owned_write();
        t_out();
        t_clamp();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #400us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule